// File: doc/BRIEF.md
# Timer Counter Clock Selector

This block picks the event that advances a 16-bit timer counter and turns it into a one-cycle count-enable pulse in the system clock domain. It offers three kinds of source:

- **The system clock.** It can be taken undivided, or as ticks from a free-running divider at one quarter, one sixteenth or one sixty-fourth of its rate.
- **Four external clock pins.** They pass through a two-flop synchronizer before edge detection.
- **A cascade pulse.** This is the overflow or underflow of a neighbouring channel.

A 3-bit source field and a 2-bit edge field choose what is counted. The edge field selects rising, falling or both edges. Counting both edges of a divided clock doubles the count rate, so one quarter of the clock on both edges counts like one half on rising edges.

The edge field has no effect in three cases: the undivided clock, the cascade source, and phase-counting mode. In phase-counting mode a separate decoder owns the counter, so this block keeps its enable low. Changing the source field clears the edge history, so the switch itself never produces a count.

All inputs are plain control and level signals. The enable is a bare one-cycle pulse with no handshake and no back-pressure: the counter that consumes it must act on it in the cycle it is high. A small counter advanced by the enable is also brought out, so that count rates can be observed.

Top module: `tcs_clock_select`

## Requirements
- R1: While reset is low, `count_en` and `count_val` are 0, and both stay 0 after reset for as long as nothing qualifies.
- R2: Source select 000 gives an enable on every cycle, whatever the value of `edge_sel`.
- R3: Source select 001, 010 and 011 with edge select 00 (rising) give exactly one enable per 4, 16 and 64 cycles respectively.
- R4: Edge select 01 (falling) on a divided source gives the same rate as rising edges, with enables taken at the divider wrap instead of its half-period point.
- R5: Edge select 10 or 11 (both edges) on a divided source gives twice the rate: two enables per divided period.
- R6: Source select 100, 101, 110 and 111 count edges of pin bits 0, 1, 2 and 3 of `ext_pins`, using the edge chosen by `edge_sel`. Activity on an unselected pin produces no enable.
- R7: With `use_cascade` high and phase mode off, each cycle in which `cascade_in` is high yields one enable on the next cycle. `src_sel` and `edge_sel` are ignored.
- R8: With `phase_mode` high, `count_en` is low on the following cycle, whatever the source, cascade and edge settings.
- R9: In the cycle after `src_sel` changes, with cascade and phase mode off, no enable is produced, even if the old and new pins sit at different levels.
- R10: `count_en` comes from a register and is high for one cycle per qualifying edge. On a divided source two enables are never adjacent.
- R11: `count_val` rises by exactly one, modulo 2^16, after each cycle in which `count_en` is high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Source: 000 undivided, 001 /4, 010 /16, 011 /64, 1xx external pin xx |
| edge_sel | input | 2 | 00 rising, 01 falling, 1x both |
| ext_pins | input | 4 | Asynchronous external clock pins |
| use_cascade | input | 1 | Count the cascade input instead of `src_sel` |
| cascade_in | input | 1 | Overflow/underflow pulse from another channel (system-clock domain) |
| phase_mode | input | 1 | Phase counting active; this block's enable is held low |
| count_en | output | 1 | One-cycle count-enable pulse |
| count_val | output | 16 | Counter advanced by `count_en` |

## Verification
Each result has a fixed latency:

- **Cascade and phase-mode inputs, and a source switch:** act on `count_en` one edge later.
- **Divider ticks:** one edge later.
- **Pin transitions:** three edges later (two synchronizer stages plus the output register).
- **`count_val`:** one further edge after `count_en`.

The bench never predicts a single cycle for pin activity. It opens a counting window only after several quiet settling cycles and closes it only after at least eight quiet cycles following the last stimulus, so every due pulse falls inside its window. Divided-clock windows are whole multiples of the divider period, which makes the expected count exact whatever the divider phase.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int SRC_W    = 3;
  localparam int EDGE_W   = 2;
  localparam int NUM_PINS = 4;
  localparam int NUM_DIV  = 3;
  localparam int DIV_STEP = 2;

  typedef enum logic [EDGE_W-1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_BOTH_ALT = 2'b11
  } edge_mode_e;

  // Choose which detected edges qualify under the edge field.
  function automatic logic edge_pick(input logic [EDGE_W-1:0] mode,
                                     input logic rise, input logic fall);
    edge_mode_e m;
    m = edge_mode_e'(mode);
    case (m)
      EDGE_RISE: edge_pick = rise;
      EDGE_FALL: edge_pick = fall;
      default:   edge_pick = rise | fall;
    endcase
  endfunction
endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int NUM_DIV  = 3,
  parameter int DIV_STEP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_DIV-1:0] rise_tick,
  output logic [NUM_DIV-1:0] fall_tick
);
  localparam int PRE_W = NUM_DIV * DIV_STEP;

  logic [PRE_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end

  // Stage g divides by 2**(DIV_STEP*(g+1)); the divided level is the
  // stage's top bit, so it rises at the half point and falls at the wrap.
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_stage
    localparam int K = DIV_STEP * (g + 1);
    localparam logic [K-1:0] HALF = {1'b1, {(K-1){1'b0}}};
    assign rise_tick[g] = (div_cnt[K-1:0] == HALF);
    assign fall_tick[g] = (div_cnt[K-1:0] == '0);
  end
endmodule

// File: rtl/tcs_sync2.sv
module tcs_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tcs_edge_det.sv
module tcs_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic clear,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  // clear masks the comparison while history is reloaded from the new pin
  assign rise = level & ~prev & ~clear;
  assign fall = ~level & prev & ~clear;
endmodule

// File: rtl/tcs_clock_select.sv
module tcs_clock_select
  import tcs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_sel,
  input  logic [EDGE_W-1:0] edge_sel,
  input  logic [NUM_PINS-1:0] ext_pins,
  input  logic              use_cascade,
  input  logic              cascade_in,
  input  logic              phase_mode,
  output logic              count_en,
  output logic [CNT_W-1:0]  count_val
);
  logic [SRC_W-1:0]    src_q;
  logic                switched;
  logic [NUM_PINS-1:0] pins_s;
  logic                ext_level, ext_rise, ext_fall;
  logic [NUM_DIV-1:0]  div_rise_v, div_fall_v;
  logic                div_rise, div_fall;
  logic                qualify;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_sel;
  end
  assign switched = (src_sel != src_q);

  tcs_sync2 #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pins), .q(pins_s)
  );

  assign ext_level = pins_s[src_sel[1:0]];

  tcs_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .level(ext_level), .clear(switched),
    .rise(ext_rise), .fall(ext_fall)
  );

  tcs_prescaler #(.NUM_DIV(NUM_DIV), .DIV_STEP(DIV_STEP)) u_pre (
    .clk(clk), .rst_n(rst_n), .rise_tick(div_rise_v), .fall_tick(div_fall_v)
  );

  always_comb begin
    div_rise = 1'b0;
    div_fall = 1'b0;
    for (int g = 0; g < NUM_DIV; g++) begin
      if (int'(src_sel[1:0]) == g + 1) begin
        div_rise = div_rise_v[g];
        div_fall = div_fall_v[g];
      end
    end
  end

  // Priority: phase counting, then cascade, then the switch guard.
  always_comb begin
    qualify = 1'b0;
    if (phase_mode)            qualify = 1'b0;
    else if (use_cascade)      qualify = cascade_in;
    else if (!switched) begin
      if (src_sel[SRC_W-1])    qualify = edge_pick(edge_sel, ext_rise, ext_fall);
      else if (src_sel[1:0] == 2'd0) qualify = 1'b1;
      else                     qualify = edge_pick(edge_sel, div_rise, div_fall);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_en  <= 1'b0;
      count_val <= '0;
    end else begin
      count_en  <= qualify;
      if (count_en) count_val <= count_val + 1'b1;
    end
  end
endmodule

module tcs_clock_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  src_sel,
  input logic        use_cascade,
  input logic        cascade_in,
  input logic        phase_mode,
  input logic        count_en,
  input logic [15:0] count_val
);
  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |=> count_val == $past(count_val) + 16'd1);
  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable(count_val));
  // R8
  phase_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_mode |=> !count_en);
  // R7
  cascade_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_cascade && !phase_mode) |=> count_en == $past(cascade_in));
  // R9
  switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_mode && !use_cascade && src_sel != $past(src_sel)) |=> !count_en);
  // R2
  undivided_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_mode && !use_cascade && src_sel == 3'd0 && $past(src_sel) == 3'd0)
    |=> count_en);
  // R10
  div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !phase_mode && !use_cascade && src_sel inside {3'd1, 3'd2, 3'd3}
     && $past(src_sel) == src_sel) |=> !count_en);
endmodule

bind tcs_clock_select tcs_clock_select_chk u_chk (.*);

// File: tb/tcs_clock_select_tb_top.sv
module tcs_clock_select_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_sel = 3'd0;
  logic [1:0]  edge_sel = 2'd0;
  logic [3:0]  ext_pins = 4'd0;
  logic        use_cascade = 1'b0;
  logic        cascade_in = 1'b0;
  logic        phase_mode = 1'b1;
  logic        count_en;
  logic [15:0] count_val;

  int n_cmp = 0, n_bad = 0;
  int seen = 0, adj = 0, total = 0;
  bit win = 0, prev_en = 0, done = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    mode_q[$];
  event  close_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcs_clock_select dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .edge_sel(edge_sel),
    .ext_pins(ext_pins), .use_cascade(use_cascade), .cascade_in(cascade_in),
    .phase_mode(phase_mode), .count_en(count_en), .count_val(count_val)
  );

  // Sampler: just after each rising edge.
  always begin
    @(posedge clk);
    #1;
    if (rst_n && count_en) total++;
    if (win) begin
      if (count_en) begin
        seen++;
        if (prev_en) adj++;
      end
      prev_en = count_en;
    end else prev_en = 0;
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item when a window closes.
  initial forever begin
    @(close_ev);
    begin
      int e; string t; bit m;
      e = exp_q.pop_front(); t = tag_q.pop_front(); m = mode_q.pop_front();
      check(t, m ? adj : seen, e);
      seen = 0; adj = 0;
    end
  end

  task automatic cfg(input logic [2:0] s, input logic [1:0] e,
                     input logic c, input logic p);
    @(negedge clk);
    src_sel = s; edge_sel = e; use_cascade = c; phase_mode = p;
    repeat (6) @(negedge clk);
  endtask

  task automatic open_win();
    @(negedge clk);
    win = 1;
  endtask

  task automatic close_win(string tag, int exp, bit m);
    @(negedge clk);
    win = 0;
    exp_q.push_back(exp); tag_q.push_back(tag); mode_q.push_back(m);
    -> close_ev;
    #1;
  endtask

  task automatic timed_win(int n, string tag, int exp, bit m);
    open_win();
    repeat (n - 1) @(negedge clk);
    close_win(tag, exp, m);
  endtask

  task automatic pulse_pin(int idx, int k);
    for (int i = 0; i < k; i++) begin
      ext_pins[idx] = 1'b1; repeat (4) @(negedge clk);
      ext_pins[idx] = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count_en in reset", int'(count_en), 0);
    check("R1 count_val in reset", int'(count_val), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 count_val idle after reset", int'(count_val), 0);

    // R2 undivided clock, edge field ignored
    cfg(3'd0, 2'b00, 0, 0); timed_win(64, "R2 undivided rise", 64, 0);
    cfg(3'd0, 2'b01, 0, 0); timed_win(64, "R2 undivided fall", 64, 0);
    // R3 rising
    cfg(3'd1, 2'b00, 0, 0); timed_win(256, "R3 div4 rise", 64, 0);
    cfg(3'd2, 2'b00, 0, 0); timed_win(256, "R3 div16 rise", 16, 0);
    cfg(3'd3, 2'b00, 0, 0); timed_win(256, "R3 div64 rise", 4, 0);
    // R4 falling
    cfg(3'd2, 2'b01, 0, 0); timed_win(256, "R4 div16 fall", 16, 0);
    cfg(3'd3, 2'b01, 0, 0); timed_win(256, "R4 div64 fall", 4, 0);
    // R5 both edges
    cfg(3'd1, 2'b10, 0, 0); timed_win(256, "R5 div4 both", 128, 0);
    cfg(3'd2, 2'b11, 0, 0); timed_win(256, "R5 div16 both", 32, 0);
    // R10 no adjacent enables on div4 both
    cfg(3'd1, 2'b10, 0, 0); timed_win(256, "R10 div4 adjacent", 0, 1);

    // R6 external pins
    cfg(3'd4, 2'b00, 0, 0); open_win(); pulse_pin(0, 5); close_win("R6 pin0 rise", 5, 0);
    cfg(3'd5, 2'b01, 0, 0); open_win(); pulse_pin(1, 4); close_win("R6 pin1 fall", 4, 0);
    cfg(3'd6, 2'b10, 0, 0); open_win(); pulse_pin(2, 3); close_win("R6 pin2 both", 6, 0);
    cfg(3'd7, 2'b11, 0, 0); open_win(); pulse_pin(3, 2); close_win("R6 pin3 both", 4, 0);
    cfg(3'd4, 2'b10, 0, 0); open_win(); pulse_pin(3, 3); close_win("R6 unselected pin", 0, 0);

    // R7 cascade, src 000 would otherwise count every cycle
    cfg(3'd0, 2'b10, 1, 0);
    open_win();
    for (int i = 0; i < 7; i++) begin
      cascade_in = 1'b1; @(negedge clk);
      cascade_in = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    close_win("R7 cascade", 7, 0);

    // R8 phase mode overrides undivided source and cascade
    cfg(3'd0, 2'b00, 1, 1);
    open_win();
    for (int i = 0; i < 5; i++) begin
      cascade_in = 1'b1; @(negedge clk);
      cascade_in = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    close_win("R8 phase mode", 0, 0);

    // R9 switching between pins at different levels
    @(negedge clk); ext_pins = 4'b0101;
    cfg(3'd4, 2'b10, 0, 0);
    open_win();
    src_sel = 3'd5; repeat (4) @(negedge clk);
    src_sel = 3'd6; repeat (4) @(negedge clk);
    src_sel = 3'd5; repeat (4) @(negedge clk);
    src_sel = 3'd4; repeat (8) @(negedge clk);
    close_win("R9 source switch", 0, 0);

    // R11 count_val tracks every enable
    cfg(3'd0, 2'b00, 0, 1);
    @(negedge clk);
    check("R11 count_val total", int'(count_val), total % 65536);

    done = 1;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule